// File: doc/BRIEF.md
# Pin and Oscillator Interrupt Request Conditioner

This block turns two interrupt sources into pending request flags for a downstream interrupt controller. The first source is an external pin. A detection-mode input picks edge or level sensing. A single pin-gate control picks one of two pins and, with it, the polarity. With the gate at 0, pin A is used, rising edges count and high is active. With the gate at 1, pin B is used, falling edges count and low is active. Both pins pass through a synchronizer. The pin source is only observed while a global port-input enable is high.

The second source is internal. When its gate control is 1, it requests service on every second tick of a slow oscillator. The tick arrives as a one-cycle pulse in the system clock domain. When that gate is 0, it requests once each time the oscillator resumes from suspend, which arrives as a one-cycle resume pulse. Both pending flags come out of reset set, so software clears them before it enables the interrupts. Each flag has its own clear strobe. A new request always takes precedence over a clear in the same cycle. Arbitration and vectoring belong to the consumer.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, the internal pending flag reads 1, and the pin pending output reads 1 while edge mode (mode input = 1) is selected. Each stays 1 until its clear strobe is pulsed.
- R2: With pin-gate = 0 in edge mode, a rising edge on pin A sets the pin pending flag. A falling edge on pin A and any activity on pin B leave it clear.
- R3: With pin-gate = 1 in edge mode, a falling edge on pin B sets the pin pending flag. A rising edge on pin B and any activity on pin A leave it clear.
- R4: In edge mode the pin pending flag stays set until the pin clear strobe is sampled high. It then reads 0 from the following cycle on.
- R5: If the pin clear strobe is high in the same cycle that a new qualifying edge is registered, the pin pending flag stays 1.
- R6: In level mode (mode input = 0), the pin pending output follows the synchronized active level and holds no state. That level is pin A high for gate 0 and pin B low for gate 1. A pin change shows at the output two clock edges after it is applied and not after one.
- R7: While the port-input enable is 0, the pin source produces no request. The level-mode output reads 0 and edges do not set the edge flag.
- R8: With the internal gate = 1, the internal pending flag is set on every second slow-oscillator tick, counting from the tick after the gate was raised. Resume pulses have no effect.
- R9: With the internal gate = 0, an oscillator-resume pulse sets the internal pending flag and slow-oscillator ticks have no effect.
- R10: The internal pending flag stays set until its clear strobe is sampled high. A clear in the same cycle as a new internal request leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Global port-input enable; the pins are ignored while it is low |
| pin_a | input | 1 | Pin used when pin-gate is 0 (rising / active high) |
| pin_b | input | 1 | Pin used when pin-gate is 1 (falling / active low) |
| edge_mode | input | 1 | 1 = edge detection, 0 = level detection for the pin source |
| pin_gate | input | 1 | Selects the pin and its polarity |
| osc_gate | input | 1 | 1 = periodic slow-oscillator requests, 0 = resume requests |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator cycle |
| osc_resume | input | 1 | One-cycle pulse when the oscillator leaves suspend |
| pin_clr | input | 1 | Clear strobe for the pin pending flag |
| osc_clr | input | 1 | Clear strobe for the internal pending flag |
| pin_pend | output | 1 | Pin interrupt pending |
| osc_pend | output | 1 | Internal interrupt pending |

## Verification
The pin source is driven with rising and falling transitions on the selected pin and on the unselected one, under both gate settings. This shows that selection and polarity move together. Level mode is driven with pulses that rise and then fall back, which tells a following output apart from a latching one, and it is sampled one and two edges after each change to pin down the synchronizer depth. The internal source gets single and paired ticks, which separate a divide-by-two from a pass-through, and resume pulses under both gate values. Clears are placed in exactly the cycle in which a new request is registered, to confirm that the request wins.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   // Which pin the pin source reads, and with which polarity
   typedef enum logic {
      SEL_A_HIGH = 1'b0,
      SEL_B_LOW  = 1'b1
   } pin_sel_e;

   typedef struct packed {
      logic a;
      logic b;
   } pin_pair_t;

   // Map the selected pin onto an active-high request level
   function automatic logic active_level(pin_pair_t p, pin_sel_e sel);
      return (sel == SEL_B_LOW) ? ~p.b : p.a;
   endfunction

   // Sticky flag update: a new request beats a same-cycle clear
   function automatic logic sticky_next(logic cur, logic set, logic clr);
      if (set)
         return 1'b1;
      else if (clr)
         return 1'b0;
      else
         return cur;
   endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int WIDTH   = 2,
   parameter int STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ext_irq_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ext_irq_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  chain[s] <= {WIDTH{RST_VAL}};
               else
                  chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  chain[s] <= {WIDTH{RST_VAL}};
               else
                  chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[LAST];

endmodule

// File: rtl/ext_irq_pin_det.sv
module ext_irq_pin_det
   import ext_irq_pkg::*;
#(
   parameter bit FLAG_RST = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      port_en,
   input  pin_pair_t pins_s,
   input  logic      edge_mode,
   input  logic      pin_gate,
   input  logic      clr,
   output logic      pend,
   output logic      edge_hit
);

   pin_sel_e sel;
   logic     act;
   logic     act_q;
   logic     flag;

   assign sel = pin_sel_e'(pin_gate);
   assign act = port_en & active_level(pins_s, sel);

   // act_q resets high so the reset release cannot fake an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= 1'b1;
      else
         act_q <= act;
   end

   assign edge_hit = act & ~act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= FLAG_RST;
      else
         flag <= sticky_next(flag, edge_hit, clr);
   end

   assign pend = edge_mode ? flag : act;

endmodule

// File: rtl/ext_irq_osc_src.sv
module ext_irq_osc_src
   import ext_irq_pkg::*;
#(
   parameter int TICK_DIV = 2,
   parameter bit FLAG_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_gate,
   input  logic slow_tick,
   input  logic osc_resume,
   input  logic clr,
   output logic pend,
   output logic req
);

   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("ext_irq_osc_src: TICK_DIV must be at least 1");
      end
   endgenerate

   logic periodic;
   logic flag;

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign periodic = slow_tick;
      end else begin : g_divided
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt;
         // Counter is held at zero while the periodic mode is off
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!osc_gate)
               cnt <= '0;
            else if (slow_tick)
               cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
         assign periodic = slow_tick && (cnt == LAST);
      end
   endgenerate

   assign req = osc_gate ? periodic : osc_resume;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= FLAG_RST;
      else
         flag <= sticky_next(flag, req, clr);
   end

   assign pend = flag;

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
   import ext_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic port_en,
   input  logic pin_a,
   input  logic pin_b,
   input  logic edge_mode,
   input  logic pin_gate,
   input  logic osc_gate,
   input  logic slow_tick,
   input  logic osc_resume,
   input  logic pin_clr,
   input  logic osc_clr,
   output logic pin_pend,
   output logic osc_pend
);

   localparam int PIN_W = $bits(pin_pair_t);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ext_irq_cond: SYNC_STAGES must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("ext_irq_cond: TICK_DIV must be at least 1");
      end
   endgenerate

   pin_pair_t pins_raw;
   pin_pair_t pins_s;
   logic [PIN_W-1:0] pins_s_vec;
   logic pin_edge_hit;
   logic osc_req;

   assign pins_raw.a = pin_a;
   assign pins_raw.b = pin_b;

   ext_irq_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b0)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_s_vec)
   );

   assign pins_s = pin_pair_t'(pins_s_vec);

   ext_irq_pin_det #(
      .FLAG_RST(1'b1)
   ) pin_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .pins_s   (pins_s),
      .edge_mode(edge_mode),
      .pin_gate (pin_gate),
      .clr      (pin_clr),
      .pend     (pin_pend),
      .edge_hit (pin_edge_hit)
   );

   ext_irq_osc_src #(
      .TICK_DIV(TICK_DIV),
      .FLAG_RST(1'b1)
   ) osc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_gate  (osc_gate),
      .slow_tick (slow_tick),
      .osc_resume(osc_resume),
      .clr       (osc_clr),
      .pend      (osc_pend),
      .req       (osc_req)
   );

endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic pin_a,
   input logic pin_b,
   input logic edge_mode,
   input logic pin_gate,
   input logic osc_gate,
   input logic slow_tick,
   input logic osc_resume,
   input logic pin_clr,
   input logic osc_clr,
   input logic pin_pend,
   input logic osc_pend
);

   // R7
   level_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && !port_en) |-> !pin_pend);

   // R7
   edge_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && !port_en && !pin_pend) |=> (!edge_mode || !pin_pend));

   // R4
   pin_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && pin_pend && !pin_clr) |=> (!edge_mode || pin_pend));

   // R10
   osc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_pend && !osc_clr) |=> osc_pend);

   // R8
   osc_no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_pend && !slow_tick && !osc_resume) |=> !osc_pend);

   // R8
   resume_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_pend && osc_gate && !slow_tick) |=> !osc_pend);

   // R9
   tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_pend && !osc_gate && !osc_resume) |=> !osc_pend);

endmodule

bind ext_irq_cond ext_irq_cond_chk chk_i (.*);

// File: tb/ext_irq_cond_tb_top.sv
`timescale 1ns/1ps
module ext_irq_cond_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   logic port_en, pin_a, pin_b, edge_mode, pin_gate, osc_gate;
   logic slow_tick, osc_resume, pin_clr, osc_clr;
   logic pin_pend, osc_pend;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ext_irq_cond dut_i (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .pin_a(pin_a), .pin_b(pin_b),
      .edge_mode(edge_mode), .pin_gate(pin_gate), .osc_gate(osc_gate),
      .slow_tick(slow_tick), .osc_resume(osc_resume), .pin_clr(pin_clr),
      .osc_clr(osc_clr), .pin_pend(pin_pend), .osc_pend(osc_pend)
   );

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_pin();
      pin_clr = 1'b1; cyc(1); pin_clr = 1'b0; cyc(1);
   endtask

   task automatic clear_osc();
      osc_clr = 1'b1; cyc(1); osc_clr = 1'b0; cyc(1);
   endtask

   task automatic tick();
      slow_tick = 1'b1; cyc(1); slow_tick = 1'b0; cyc(1);
   endtask

   task automatic t_reset();
      chk(pin_pend, 1'b1, "R1", "pin pending after reset");
      chk(osc_pend, 1'b1, "R1", "osc pending after reset");
      cyc(3);
      chk(pin_pend, 1'b1, "R1", "pin pending held before clear");
      pin_clr = 1'b1; osc_clr = 1'b1; cyc(1);
      pin_clr = 1'b0; osc_clr = 1'b0;
      chk(pin_pend, 1'b0, "R1", "pin pending cleared");
      chk(osc_pend, 1'b0, "R1", "osc pending cleared");
   endtask

   task automatic t_gate0_edge();
      edge_mode = 1'b1; pin_gate = 1'b0; cyc(4); clear_pin();
      pin_b = 1'b0; cyc(4); pin_b = 1'b1; cyc(4);
      chk(pin_pend, 1'b0, "R2", "pin B toggles ignored with gate 0");
      pin_a = 1'b1; cyc(4);
      chk(pin_pend, 1'b1, "R2", "rising edge on pin A sets flag");
      clear_pin();
      pin_a = 1'b0; cyc(4);
      chk(pin_pend, 1'b0, "R2", "falling edge on pin A ignored");
   endtask

   task automatic t_gate1_edge();
      pin_a = 1'b0; pin_b = 1'b1; edge_mode = 1'b1; pin_gate = 1'b1; cyc(4); clear_pin();
      pin_a = 1'b1; cyc(4); pin_a = 1'b0; cyc(4);
      chk(pin_pend, 1'b0, "R3", "pin A toggles ignored with gate 1");
      pin_b = 1'b0; cyc(4);
      chk(pin_pend, 1'b1, "R3", "falling edge on pin B sets flag");
      clear_pin();
      pin_b = 1'b1; cyc(4);
      chk(pin_pend, 1'b0, "R3", "rising edge on pin B ignored");
   endtask

   task automatic t_sticky_and_race();
      pin_gate = 1'b0; edge_mode = 1'b1; pin_a = 1'b0; pin_b = 1'b1; cyc(4); clear_pin();
      pin_a = 1'b1; cyc(10);
      chk(pin_pend, 1'b1, "R4", "edge flag held without clear");
      pin_clr = 1'b1; cyc(1); pin_clr = 1'b0;
      chk(pin_pend, 1'b0, "R4", "edge flag low one cycle after clear");
      pin_a = 1'b0; cyc(4);
      // R5: new edge registered at the third edge after the pin change
      pin_a = 1'b1; cyc(2);
      pin_clr = 1'b1; cyc(1); pin_clr = 1'b0;
      chk(pin_pend, 1'b1, "R5", "clear with same-cycle edge keeps flag");
      cyc(2);
      chk(pin_pend, 1'b1, "R5", "flag still set after race");
      pin_a = 1'b0; cyc(4); clear_pin();
   endtask

   task automatic t_level();
      edge_mode = 1'b0; pin_gate = 1'b0; pin_a = 1'b0; pin_b = 1'b1; cyc(4);
      chk(pin_pend, 1'b0, "R6", "level idle gate 0");
      pin_a = 1'b1; cyc(1);
      chk(pin_pend, 1'b0, "R6", "level not visible after one edge");
      cyc(1);
      chk(pin_pend, 1'b1, "R6", "level visible after two edges");
      pin_a = 1'b0; cyc(2);
      chk(pin_pend, 1'b0, "R6", "level follows pin A low (no latch)");
      pin_gate = 1'b1; cyc(1);
      chk(pin_pend, 1'b0, "R6", "pin B high inactive with gate 1");
      pin_b = 1'b0; cyc(2);
      chk(pin_pend, 1'b1, "R6", "pin B low active with gate 1");
      pin_b = 1'b1; cyc(2);
      chk(pin_pend, 1'b0, "R6", "pin B high again releases request");
   endtask

   task automatic t_port_disable();
      edge_mode = 1'b0; pin_gate = 1'b0; port_en = 1'b0; pin_a = 1'b1; cyc(4);
      chk(pin_pend, 1'b0, "R7", "level request masked while disabled");
      edge_mode = 1'b1; pin_a = 1'b0; cyc(4); clear_pin();
      pin_a = 1'b1; cyc(4);
      chk(pin_pend, 1'b0, "R7", "edge ignored while disabled");
      pin_a = 1'b0; cyc(4); port_en = 1'b1; cyc(4);
      chk(pin_pend, 1'b0, "R7", "no request after re-enable with idle pin");
   endtask

   task automatic t_periodic();
      osc_gate = 1'b1; cyc(2); clear_osc();
      tick();
      chk(osc_pend, 1'b0, "R8", "first tick gives no request");
      tick();
      chk(osc_pend, 1'b1, "R8", "second tick sets request");
      clear_osc();
      tick();
      chk(osc_pend, 1'b0, "R8", "third tick gives no request");
      tick();
      chk(osc_pend, 1'b1, "R8", "fourth tick sets request");
      clear_osc();
      osc_resume = 1'b1; cyc(1); osc_resume = 1'b0; cyc(1);
      chk(osc_pend, 1'b0, "R8", "resume ignored in periodic mode");
   endtask

   task automatic t_resume();
      osc_gate = 1'b0; cyc(2); clear_osc();
      tick(); tick(); tick();
      chk(osc_pend, 1'b0, "R9", "ticks ignored in resume mode");
      osc_resume = 1'b1; cyc(1); osc_resume = 1'b0;
      chk(osc_pend, 1'b1, "R9", "resume pulse sets request");
      cyc(6);
      chk(osc_pend, 1'b1, "R10", "osc flag held without clear");
      clear_osc();
      chk(osc_pend, 1'b0, "R10", "osc flag cleared");
      osc_resume = 1'b1; osc_clr = 1'b1; cyc(1);
      osc_resume = 1'b0; osc_clr = 1'b0;
      chk(osc_pend, 1'b1, "R10", "clear with same-cycle request keeps flag");
      clear_osc();
   endtask

   initial begin
      rst_n = 1'b0; port_en = 1'b1; pin_a = 1'b0; pin_b = 1'b1;
      edge_mode = 1'b1; pin_gate = 1'b0; osc_gate = 1'b0;
      slow_tick = 1'b0; osc_resume = 1'b0; pin_clr = 1'b0; osc_clr = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_gate0_edge();
      t_gate1_edge();
      t_sticky_and_race();
      t_level();
      t_port_disable();
      t_periodic();
      t_resume();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule